// File: doc/BRIEF.md
# Register Window Direct-Write Sequencer

This block steers unbuffered serial writes into a small window of directly writable registers. The window holds clock, port-output and battery-backed RAM bytes, and it occupies addresses 0x120 to 0x135. A serial front end marks the start of a write transaction and supplies the start address. It then reports each completed data byte and finally the rising edge of chip select. The sequencer decides whether each byte may land, emits a one-cycle write strobe with address and data to the register file, and moves its address pointer. When the transaction closes, it says whether the write-enable latch must be cleared.

The pointer normally counts upward and wraps from the last window address back to the first, so a master may stream bytes without limit. A start address on either of the two port-output registers, with the port output mode at 0, makes the pointer bounce between those two registers instead. This lets the master produce fast patterns on the port pins. Two commit timings are supported. In the first, every byte is written as soon as it is complete. In the second, each byte is held until the next byte completes or chip select rises, so the final byte is committed at the end of the transaction. The front end only ever reports whole bytes, and it never reports a byte and the chip-select rise in the same cycle.

Top module: `regwin_write_seq`

## Requirements
- R1: In immediate commit mode (`mode_deferred`=0), the cycle after a `byte_done` pulse shows `wr_stb`=1 with `wr_addr` equal to the current pointer and `wr_data` equal to `byte_data`. This happens only when `wen`=1, `reg_protect`=0 and the address is writeable.
- R2: The pointer advances after every completed byte. From 0x135 it wraps to 0x120, and a stream of any length keeps wrapping.
- R3: Bit k of `ro_map` set to 1 marks address 0x120+k read-only. A byte aimed at that address produces no strobe, and the pointer still advances past it.
- R4: One cycle after `cs_rise`, `wen_clear` pulses high for exactly one cycle, and only if at least one strobe was issued for the transaction, including a final deferred byte.
- R5: With `reg_protect`=1 or `wen`=0, no byte is written and `wen_clear` stays low.
- R6: A start address of 0x120 or 0x121 with `out_mode`=0 makes the pointer alternate between 0x120 and 0x121 after each byte. With `out_mode`=1, or with any other start address, the pointer increments.
- R7: In deferred commit mode (`mode_deferred`=1), the strobe for a byte appears the cycle after the next `byte_done`. The last byte is strobed the cycle after `cs_rise`, in the same cycle as `wen_clear`.
- R8: A start address outside 0x120 to 0x135 is rejected. No strobe is issued and `wen_clear` stays low.
- R9: After reset, `wr_stb` and `wen_clear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Pulse: a write transaction begins; `start_addr` valid |
| start_addr | input | 9 | Target address sent after the instruction |
| byte_done | input | 1 | Pulse: a complete data byte is on `byte_data` |
| byte_data | input | 8 | Completed data byte |
| cs_rise | input | 1 | Pulse: chip select rose, transaction ends |
| mode_deferred | input | 1 | 0 commit each byte at once, 1 hold each byte until the next event |
| wen | input | 1 | Current write-enable latch |
| reg_protect | input | 1 | 1 blocks all register updates |
| out_mode | input | 1 | Port output mode; 0 enables pair toggling |
| ro_map | input | 22 | Per-address read-only flags, bit k for 0x120+k |
| wr_stb | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 9 | Write address |
| wr_data | output | 8 | Write data |
| wen_clear | output | 1 | One-cycle request to clear write-enable |

## Verification
The bench builds the block with its default window of base 0x120 and depth 22. This depth is not a power of two, so the comparison-based wrap is selected. With read-only flags on 0x123 and 0x124, a 50-byte stream passes the wrap point twice and crosses the read-only pair three times, which makes the skip count and the final address exact. The same defaults put both neighbours of the window, 0x11F and 0x136, within reach as rejected start addresses. They also let the port-register pair be tested in both output modes and under both commit timings.

// File: rtl/rw_pkg.sv
package rw_pkg;

  // Commit timing for completed bytes.
  typedef enum logic {
    COMMIT_AT_BYTE  = 1'b0,
    COMMIT_DEFERRED = 1'b1
  } commit_e;

endpackage

// File: rtl/rw_rst_sync.sv
module rw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/rw_ptr_gen.sv
module rw_ptr_gen #(
  parameter  int ADDR_W = 9,
  parameter  int BASE   = 288,
  parameter  int DEPTH  = 22,
  localparam int OFF_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              out_mode,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic [OFF_W-1:0]  off,
  output logic              in_win
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] PAIR_A = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              tog_q, tog_d;
  logic [ADDR_W-1:0] inc;

  // Wrap variant chosen by window geometry.
  generate
    if (((DEPTH & (DEPTH - 1)) == 0) && ((BASE % DEPTH) == 0)) begin : g_mask_wrap
      localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(DEPTH - 1);
      assign inc = (ptr_q & ~MASK_A) | ((ptr_q + 1'b1) & MASK_A);
    end else begin : g_cmp_wrap
      assign inc = (ptr_q == LAST_A) ? BASE_A : ptr_q + 1'b1;
    end
  endgenerate

  assign in_win = (start_addr >= BASE_A) && (start_addr <= LAST_A);

  always_comb begin
    ptr_d = ptr_q;
    tog_d = tog_q;
    if (load) begin
      ptr_d = start_addr;
      tog_d = !out_mode && ((start_addr == BASE_A) || (start_addr == PAIR_A));
    end else if (adv) begin
      if (tog_q) begin
        ptr_d = (ptr_q == BASE_A) ? PAIR_A : BASE_A;
      end else begin
        ptr_d = inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= BASE_A;
      tog_q <= 1'b0;
    end else if (load || adv) begin
      ptr_q <= ptr_d;
      tog_q <= tog_d;
    end
  end

  assign ptr = ptr_q;
  assign off = OFF_W'(ptr_q - BASE_A);

endmodule

// File: rtl/rw_commit_stage.sv
module rw_commit_stage
  import rw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  commit_e           mode,
  input  logic              clr,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_ok,
  input  logic              flush,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit_ok
);

  logic              pend_v_q, pend_v_d;
  logic              pend_ok_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              pend_load;

  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] addr_q, sel_addr;
  logic [DATA_W-1:0] data_q, sel_data;

  always_comb begin
    stb_d    = 1'b0;
    sel_addr = cap_addr;
    sel_data = cap_data;
    if (mode == COMMIT_AT_BYTE) begin
      stb_d = cap && cap_ok;
    end else begin
      stb_d    = (cap || flush) && pend_v_q && pend_ok_q;
      sel_addr = pend_addr_q;
      sel_data = pend_data_q;
    end

    pend_load = (mode == COMMIT_DEFERRED) && cap;
    pend_v_d  = pend_v_q;
    if (clr || flush) pend_v_d = 1'b0;
    if (pend_load)    pend_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q       <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      pend_v_q    <= 1'b0;
      pend_ok_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      stb_q    <= stb_d;
      pend_v_q <= pend_v_d;
      if (stb_d) begin
        addr_q <= sel_addr;
        data_q <= sel_data;
      end
      if (pend_load) begin
        pend_ok_q   <= cap_ok;
        pend_addr_q <= cap_addr;
        pend_data_q <= cap_data;
      end
    end
  end

  assign wr_stb    = stb_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign commit_ok = stb_d;

endmodule

// File: rtl/rw_wen_track.sv
module rw_wen_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic commit_ok,
  input  logic txn_end,
  output logic wen_clear
);

  logic hit_q, hit_d;
  logic clr_q, clr_d;

  always_comb begin
    clr_d = txn_end && (hit_q || commit_ok);
    if (clr || txn_end) begin
      hit_d = 1'b0;
    end else begin
      hit_d = hit_q || commit_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      clr_q <= clr_d;
    end
  end

  assign wen_clear = clr_q;

endmodule

// File: rtl/regwin_write_seq.sv
module regwin_write_seq
  import rw_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 288,
  parameter int WIN_DEPTH = 22,
  parameter int RST_SYNC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 byte_done,
  input  logic [DATA_W-1:0]    byte_data,
  input  logic                 cs_rise,
  input  logic                 mode_deferred,
  input  logic                 wen,
  input  logic                 reg_protect,
  input  logic                 out_mode,
  input  logic [WIN_DEPTH-1:0] ro_map,
  output logic                 wr_stb,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 wen_clear
);

  localparam int OFF_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;

  logic              rst_n_s;
  logic              active_q, active_d;
  commit_e           mode_q, mode_d;
  logic [ADDR_W-1:0] ptr;
  logic [OFF_W-1:0]  off;
  logic              in_win;
  logic              cap, flush, byte_ok, commit_ok;

  rw_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // Transaction state: open only for an in-window start.
  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    if (xfer_start) begin
      active_d = in_win;
      if (in_win) mode_d = commit_e'(mode_deferred);
    end else if (cs_rise) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      active_q <= 1'b0;
      mode_q   <= COMMIT_AT_BYTE;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
    end
  end

  assign cap     = byte_done && active_q;
  assign flush   = cs_rise && active_q;
  assign byte_ok = wen && !reg_protect && !ro_map[off];

  rw_ptr_gen #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE_ADDR),
    .DEPTH  (WIN_DEPTH)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (xfer_start),
    .start_addr (start_addr),
    .out_mode   (out_mode),
    .adv        (cap),
    .ptr        (ptr),
    .off        (off),
    .in_win     (in_win)
  );

  rw_commit_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode      (mode_q),
    .clr       (xfer_start),
    .cap       (cap),
    .cap_addr  (ptr),
    .cap_data  (byte_data),
    .cap_ok    (byte_ok),
    .flush     (flush),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .commit_ok (commit_ok)
  );

  rw_wen_track u_wen (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (xfer_start),
    .commit_ok (commit_ok),
    .txn_end   (flush),
    .wen_clear (wen_clear)
  );

endmodule

// File: rtl/rw_write_seq_chk.sv
module rw_write_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int BASE   = 288,
  parameter int DEPTH  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_done,
  input logic              cs_rise,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wen_clear
);

  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + DEPTH - 1);

  assert_stb_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done || cs_rise));

  assert_addr_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr >= LO && wr_addr <= HI));

  assert_clear_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clear |-> $past(cs_rise));

  assert_clear_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clear |=> !wen_clear);

endmodule

bind regwin_write_seq rw_write_seq_chk #(
  .ADDR_W (ADDR_W),
  .BASE   (BASE_ADDR),
  .DEPTH  (WIN_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_done (byte_done),
  .cs_rise   (cs_rise),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .wen_clear (wen_clear)
);

// File: tb/test_regwin_write_seq.sv
`timescale 1ns/1ps
module test_regwin_write_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_start, byte_done, cs_rise;
  logic [8:0]  start_addr;
  logic [7:0]  byte_data;
  logic        mode_deferred, wen, reg_protect, out_mode;
  logic [21:0] ro_map;
  logic        wr_stb, wen_clear;
  logic [8:0]  wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int clr_cnt = 0;
  logic [8:0] last_addr;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_write_seq i_regwin_write_seq (
    .clk (clk), .rst_n (rst_n), .xfer_start (xfer_start), .start_addr (start_addr),
    .byte_done (byte_done), .byte_data (byte_data), .cs_rise (cs_rise),
    .mode_deferred (mode_deferred), .wen (wen), .reg_protect (reg_protect),
    .out_mode (out_mode), .ro_map (ro_map), .wr_stb (wr_stb), .wr_addr (wr_addr),
    .wr_data (wr_data), .wen_clear (wen_clear)
  );

  always @(negedge clk) begin
    if (wr_stb)    begin wr_cnt++; last_addr = wr_addr; end
    if (wen_clear) clr_cnt++;
  end

  typedef struct packed {
    logic       m11;
    logic       om;
    logic       prot;
    logic       we;
    logic [8:0] sa;
    logic [7:0] nb;
    logic [7:0] ewr;
    logic [8:0] elast;
    logic       eclr;
    logic [3:0] req;
  } vec_t;

  // ro_map = 0x000018: addresses 0x123 and 0x124 are read-only.
  localparam vec_t TBL [13] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h120, 8'd3,  8'd3,  9'h122, 1'b1, 4'd1}, // R1
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h134, 8'd4,  8'd4,  9'h121, 1'b1, 4'd2}, // R2 wrap
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h122, 8'd4,  8'd2,  9'h125, 1'b1, 4'd3}, // R3 skip
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h123, 8'd2,  8'd0,  9'h000, 1'b0, 4'd4}, // R4 none
    '{1'b0, 1'b1, 1'b1, 1'b1, 9'h120, 8'd3,  8'd0,  9'h000, 1'b0, 4'd5}, // R5 prot
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'h120, 8'd3,  8'd0,  9'h000, 1'b0, 4'd5}, // R5 wen
    '{1'b0, 1'b0, 1'b0, 1'b1, 9'h121, 8'd4,  8'd4,  9'h120, 1'b1, 4'd6}, // R6 pair
    '{1'b0, 1'b0, 1'b0, 1'b1, 9'h125, 8'd2,  8'd2,  9'h126, 1'b1, 4'd6}, // R6 other
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h11F, 8'd2,  8'd0,  9'h000, 1'b0, 4'd8}, // R8 below
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h136, 8'd2,  8'd0,  9'h000, 1'b0, 4'd8}, // R8 above
    '{1'b1, 1'b1, 1'b0, 1'b1, 9'h120, 8'd2,  8'd2,  9'h121, 1'b1, 4'd7}, // R7
    '{1'b0, 1'b1, 1'b0, 1'b1, 9'h120, 8'd50, 8'd44, 9'h125, 1'b1, 4'd2}, // R2 stream
    '{1'b1, 1'b0, 1'b0, 1'b1, 9'h120, 8'd3,  8'd3,  9'h120, 1'b1, 4'd6}  // R6 + R7
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic m11, input logic om, input logic prot,
                         input logic we, input logic [8:0] sa, input int nb);
    @(negedge clk);
    mode_deferred = m11; out_mode = om; reg_protect = prot; wen = we;
    start_addr = sa; xfer_start = 1'b1; wr_cnt = 0; clr_cnt = 0;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      byte_data = 8'hA0 + 8'(i); byte_done = 1'b1;
      @(negedge clk);
      byte_done = 1'b0;
      @(negedge clk);
    end
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; xfer_start = 0; byte_done = 0; cs_rise = 0; start_addr = '0;
    byte_data = '0; mode_deferred = 0; wen = 0; reg_protect = 0; out_mode = 1;
    ro_map = 22'h000018;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(9, wr_stb, 0, "wr_stb after reset");       // R9
    chk(9, wen_clear, 0, "wen_clear after reset"); // R9

    foreach (TBL[k]) begin
      run_txn(TBL[k].m11, TBL[k].om, TBL[k].prot, TBL[k].we, TBL[k].sa, int'(TBL[k].nb));
      chk(int'(TBL[k].req), wr_cnt, 32'(TBL[k].ewr), $sformatf("row %0d writes", k));
      if (TBL[k].ewr != 0)
        chk(int'(TBL[k].req), last_addr, 32'(TBL[k].elast), $sformatf("row %0d last addr", k));
      chk(4, clr_cnt, 32'(TBL[k].eclr), $sformatf("row %0d wen_clear count", k)); // R4
    end

    // R1: immediate commit appears the cycle after the byte.
    @(negedge clk);
    mode_deferred = 0; out_mode = 1; reg_protect = 0; wen = 1;
    start_addr = 9'h128; xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    byte_data = 8'h5A; byte_done = 1;
    @(negedge clk); byte_done = 0;
    chk(1, wr_stb, 1, "immediate strobe");
    chk(1, wr_addr, 9'h128, "immediate addr");
    chk(1, wr_data, 8'h5A, "immediate data");
    cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    chk(4, wen_clear, 1, "clear after immediate write");
    @(negedge clk);
    chk(4, wen_clear, 0, "clear is one cycle");

    // R7: deferred commit holds each byte until the next event.
    mode_deferred = 1; start_addr = 9'h128; xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    byte_data = 8'h11; byte_done = 1;
    @(negedge clk); byte_done = 0;
    chk(7, wr_stb, 0, "first byte held");
    @(negedge clk);
    byte_data = 8'h22; byte_done = 1;
    @(negedge clk); byte_done = 0;
    chk(7, wr_stb, 1, "held byte released by next byte");
    chk(7, wr_addr, 9'h128, "released addr");
    chk(7, wr_data, 8'h11, "released data");
    @(negedge clk);
    chk(7, wr_stb, 0, "second byte held");
    cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    chk(7, wr_stb, 1, "final byte at transaction end");
    chk(7, wr_addr, 9'h129, "final addr");
    chk(7, wr_data, 8'h22, "final data");
    chk(4, wen_clear, 1, "clear with final byte");
    @(negedge clk);

    // R3: a write aimed at a read-only register is dropped.
    mode_deferred = 0; start_addr = 9'h124; xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    byte_data = 8'h77; byte_done = 1;
    @(negedge clk); byte_done = 0;
    chk(3, wr_stb, 0, "read-only target dropped");
    cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    chk(3, wen_clear, 0, "no clear after read-only only");
    @(negedge clk);

    done = 1;
    summary();
  end

endmodule